// File: doc/BRIEF.md
# Local Countdown Timer with Power-of-Two Prescaler

This block is the programmable timer of a per-core interrupt controller. Software loads a start value, picks a clock prescale, and chooses a vector, a mask and a repeat mode. The block then counts the value down at the prescaled rate. When a countdown runs out and the timer is not masked, it sends a single-cycle request with the 8-bit vector to the priority logic. The request is always marked as edge-triggered.

A register decoder outside the block drives three write strobes, one each for the start value, the prescale setting and the mode/vector entry. The live count and both configuration registers are visible on output ports, so the decoder can return them on reads. The block does no prioritisation and no address decoding.

The control is a two-state machine. ST_IDLE means stopped, with the count held. ST_COUNT means counting. There are four transitions. LOAD goes from either state to ST_COUNT on a nonzero start-value write. STOP goes from either state to ST_IDLE on a zero start-value write. FIRE_ONCE goes from ST_COUNT to ST_IDLE when a one-shot countdown expires. RELOAD stays in ST_COUNT when a periodic countdown expires. In every other case the state is held.

Top module: `lapic_countdown`

## Requirements
- R1: After reset, the count reads 0, no request is raised, the prescale register reads 0, the mode entry reads 0x10000 (masked, one-shot, vector 0), and the timer stays idle.
- R2: A prescale write stores `div_data & 4'hB`. Bit 2 is always dropped, and the stored value is visible on `div_readback` one clock later.
- R3: The prescale code is {stored bit 3, stored bits 1:0}. The shift is (code+1) mod 8, and the count steps once every 2^shift clocks. Code 7 (stored value 0xB) steps on every clock, and code 6 (0xA) steps every 128 clocks.
- R4: A start-value write loads the count on the next clock and clears the prescaler phase, so the first step happens 2^shift clocks after the write edge. A write during a countdown restarts it.
- R5: In one-shot mode (entry bit 17 = 0), the count falls to 0. On the next prescaled step the block raises exactly one request and goes idle, and the count stays at 0.
- R6: In periodic mode (entry bit 17 = 1), the step taken at count 0 raises a request and reloads the start value. The period is (start+1) prescaled steps.
- R7: A request is high for one clock. It carries entry bits 7:0 on `irq_vector`, and `irq_level` is 0 (edge).
- R8: When entry bit 16 (mask) is set at expiry, no request is raised, but the count reloads or stops exactly as it would when unmasked.
- R9: A start-value write of 0 stops the timer. The count becomes 0 and no request follows.
- R10: A mode-entry write keeps only bits 17, 16 and 7:0 and clears the others. The kept value is visible on `entry_readback` one clock later and is used from the next expiry on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_wr | input | 1 | Write strobe for the start value |
| init_data | input | 32 | Start value |
| div_wr | input | 1 | Write strobe for the prescale register |
| div_data | input | 4 | Prescale write data |
| entry_wr | input | 1 | Write strobe for the mode/vector entry |
| entry_data | input | 18 | Entry write data: 17 periodic, 16 mask, 7:0 vector |
| cur_count | output | 32 | Live count |
| div_readback | output | 4 | Stored prescale value |
| entry_readback | output | 18 | Stored entry |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |
| irq_level | output | 1 | Trigger mode of the request (0 = edge) |

## Verification
The results fall due at different times after a stimulus:
- The count and both readbacks change on the first rising edge after their write strobe.
- The first step of a fresh countdown lands 2^shift edges after the load edge.
- A request appears on the edge that processes the step taken at count 0. That is (start+1)·2^shift edges after the load, and then every (start+1)·2^shift edges in periodic mode.

The bench keeps an integer model that advances once per rising edge, using the strobes held since the previous falling edge. It compares count, request, vector and readbacks at every falling edge, so each result is checked in the exact cycle it is due. It also counts the requests in each phase against closed-form totals.

// File: rtl/lct_pkg.sv
package lct_pkg;

    localparam int DIV_CODE_W = 3;
    localparam int PSC_W      = (1 << DIV_CODE_W) - 1;
    localparam int DIV_W      = 4;
    localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;

    localparam int ENTRY_W    = 18;
    localparam int MODE_BIT   = 17;
    localparam int MASK_BIT   = 16;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } tmr_state_e;

    // Gather the scattered code and turn it into a shift (code+1 mod 8).
    function automatic logic [DIV_CODE_W-1:0] div_to_shift(input logic [DIV_W-1:0] d);
        logic [DIV_CODE_W-1:0] code;
        code = {d[3], d[1:0]};
        return code + 3'd1;
    endfunction

endpackage

// File: rtl/lct_regs.sv
module lct_regs
    import lct_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  div_wr,
    input  logic [DIV_W-1:0]      div_data,
    input  logic                  entry_wr,
    input  logic [ENTRY_W-1:0]    entry_data,
    output logic [DIV_CODE_W-1:0] shift,
    output logic                  periodic,
    output logic                  masked,
    output logic [VEC_W-1:0]      vector,
    output logic [DIV_W-1:0]      div_rb,
    output logic [ENTRY_W-1:0]    entry_rb
);

    localparam logic [ENTRY_W-1:0] ENTRY_KEEP =
        (ENTRY_W'(1) << MODE_BIT) | (ENTRY_W'(1) << MASK_BIT) | ENTRY_W'((1 << VEC_W) - 1);
    localparam logic [ENTRY_W-1:0] ENTRY_RESET = ENTRY_W'(1) << MASK_BIT;

    logic [DIV_W-1:0]   div_q;
    logic [ENTRY_W-1:0] entry_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_wr) begin
            div_q <= div_data & DIV_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= ENTRY_RESET;
        end else if (entry_wr) begin
            entry_q <= entry_data & ENTRY_KEEP;
        end
    end

    always_comb begin
        shift    = div_to_shift(div_q);
        periodic = entry_q[MODE_BIT];
        masked   = entry_q[MASK_BIT];
        vector   = entry_q[VEC_W-1:0];
        div_rb   = div_q;
        entry_rb = entry_q;
    end

endmodule

// File: rtl/lct_prescaler.sv
module lct_prescaler
    import lct_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  restart,
    input  logic [DIV_CODE_W-1:0] shift,
    output logic                  tick
);

    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] limit;

    always_comb begin
        limit = ~({PSC_W{1'b1}} << shift);
        // >= so that a smaller prescale written mid-phase still ends the phase
        tick  = run && (psc_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (restart || !run || tick) begin
            psc_q <= '0;
        end else begin
            psc_q <= psc_q + 1'b1;
        end
    end

endmodule

// File: rtl/lct_fsm.sv
module lct_fsm
    import lct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_wr,
    input  logic [CNT_W-1:0] init_data,
    input  logic             tick,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    output logic             run,
    output logic [CNT_W-1:0] count,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);

    tmr_state_e       state_q, state_n;
    logic [CNT_W-1:0] count_q, count_n;
    logic [CNT_W-1:0] start_q, start_n;
    logic             fire_n;
    logic             irq_q;
    logic [VEC_W-1:0] vec_q;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
            start_q <= '0;
        end else begin
            state_q <= state_n;
            count_q <= count_n;
            start_q <= start_n;
        end
    end

    // Transitions: LOAD, STOP, FIRE_ONCE, RELOAD
    always_comb begin
        state_n = state_q;
        count_n = count_q;
        start_n = start_q;
        fire_n  = 1'b0;
        if (init_wr) begin
            start_n = init_data;
            count_n = init_data;
            state_n = (init_data == '0) ? ST_IDLE : ST_COUNT;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_n = ST_IDLE;
                end
                ST_COUNT: begin
                    if (tick) begin
                        if (count_q != '0) begin
                            count_n = count_q - 1'b1;
                        end else begin
                            fire_n = !masked;
                            if (periodic) begin
                                count_n = start_q;
                            end else begin
                                state_n = ST_IDLE;
                            end
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= fire_n;
            if (fire_n) begin
                vec_q <= vector;
            end
        end
    end

    always_comb begin
        run        = (state_q == ST_COUNT);
        count      = count_q;
        irq_valid  = irq_q;
        irq_vector = vec_q;
    end

endmodule

// File: rtl/lapic_countdown.sv
module lapic_countdown
    import lct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_wr,
    input  logic [CNT_W-1:0]   init_data,
    input  logic               div_wr,
    input  logic [DIV_W-1:0]   div_data,
    input  logic               entry_wr,
    input  logic [ENTRY_W-1:0] entry_data,
    output logic [CNT_W-1:0]   cur_count,
    output logic [DIV_W-1:0]   div_readback,
    output logic [ENTRY_W-1:0] entry_readback,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vector,
    output logic               irq_level
);

    localparam logic TRIG_EDGE = 1'b0;

    logic [DIV_CODE_W-1:0] shift;
    logic                  periodic;
    logic                  masked;
    logic [VEC_W-1:0]      vector;
    logic                  run;
    logic                  tick;

    lct_regs #(.VEC_W(VEC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_wr     (div_wr),
        .div_data   (div_data),
        .entry_wr   (entry_wr),
        .entry_data (entry_data),
        .shift      (shift),
        .periodic   (periodic),
        .masked     (masked),
        .vector     (vector),
        .div_rb     (div_readback),
        .entry_rb   (entry_readback)
    );

    lct_prescaler u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (init_wr),
        .shift   (shift),
        .tick    (tick)
    );

    lct_fsm #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_wr    (init_wr),
        .init_data  (init_data),
        .tick       (tick),
        .periodic   (periodic),
        .masked     (masked),
        .vector     (vector),
        .run        (run),
        .count      (cur_count),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    assign irq_level = TRIG_EDGE;

endmodule

// File: rtl/lct_checker.sv
module lct_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_wr,
    input logic [CNT_W-1:0] init_data,
    input logic             div_wr,
    input logic [3:0]       div_data,
    input logic [CNT_W-1:0] cur_count,
    input logic [3:0]       div_readback,
    input logic             rb_mask,
    input logic             irq_valid,
    input logic             irq_level
);

    assert_div_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> div_readback == ($past(div_data) & 4'hB));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_wr && cur_count != '0) |=>
        (cur_count == $past(cur_count) || cur_count == $past(cur_count) - 1'b1));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> cur_count == $past(init_data));

    assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    assert_edge_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !irq_level);

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(rb_mask));

    assert_zero_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_wr && init_data == '0) |=> (cur_count == '0 && !irq_valid));

endmodule

bind lapic_countdown lct_checker #(.CNT_W(CNT_W)) i_lct_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_wr      (init_wr),
    .init_data    (init_data),
    .div_wr       (div_wr),
    .div_data     (div_data),
    .cur_count    (cur_count),
    .div_readback (div_readback),
    .rb_mask      (entry_readback[16]),
    .irq_valid    (irq_valid),
    .irq_level    (irq_level)
);

// File: tb/test_lapic_countdown.sv
module test_lapic_countdown;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_wr = 1'b0;
    logic [31:0] init_data = '0;
    logic        div_wr = 1'b0;
    logic [3:0]  div_data = '0;
    logic        entry_wr = 1'b0;
    logic [17:0] entry_data = '0;
    logic [31:0] cur_count;
    logic [3:0]  div_readback;
    logic [17:0] entry_readback;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic        irq_level;

    always #4 clk = ~clk;

    lapic_countdown i_lapic_countdown (
        .clk            (clk),
        .rst_n          (rst_n),
        .init_wr        (init_wr),
        .init_data      (init_data),
        .div_wr         (div_wr),
        .div_data       (div_data),
        .entry_wr       (entry_wr),
        .entry_data     (entry_data),
        .cur_count      (cur_count),
        .div_readback   (div_readback),
        .entry_readback (entry_readback),
        .irq_valid      (irq_valid),
        .irq_vector     (irq_vector),
        .irq_level      (irq_level)
    );

    int     errors = 0;
    int     checks = 0;
    int     irq_seen = 0;
    string  req = "R1";

    // behavioural reference state
    longint m_cnt, m_start;
    int     m_psc, m_vec;
    bit     m_run, m_irq;
    int     m_div, m_entry;

    task automatic chk(input string r, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_start = 0; m_psc = 0; m_vec = 0;
        m_run = 0; m_irq = 0; m_div = 0; m_entry = 'h10000;
    endtask

    task automatic model_edge();
        int code, shift;
        if (!rst_n) begin
            model_reset();
            return;
        end
        code  = ((m_div >> 1) & 4) | (m_div & 3);
        shift = (code + 1) % 8;
        m_irq = 0;
        if (init_wr) begin
            m_cnt = init_data; m_start = init_data; m_psc = 0;
            m_run = (init_data != 0);
        end else if (m_run) begin
            if (m_psc >= (1 << shift) - 1) begin
                m_psc = 0;
                if (m_cnt > 0) m_cnt = m_cnt - 1;
                else begin
                    m_irq = ((m_entry >> 16) & 1) == 0;
                    m_vec = m_entry & 'hFF;
                    if (((m_entry >> 17) & 1) == 1) m_cnt = m_start;
                    else m_run = 0;
                end
            end else begin
                m_psc = m_psc + 1;
            end
        end else begin
            m_psc = 0;
        end
        if (div_wr)   m_div = div_data & 'hB;
        if (entry_wr) m_entry = entry_data & 'h300FF;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(req, "count", cur_count, m_cnt);
        chk(req, "irq_valid", irq_valid, m_irq);
        chk(req, "div_readback R2", div_readback, m_div);
        chk(req, "entry_readback R10", entry_readback, m_entry);
        if (m_irq) begin
            chk("R7", "irq_vector", irq_vector, m_vec);
            chk("R7", "irq_level", irq_level, 0);
        end
        if (irq_valid) irq_seen++;
        init_wr = 1'b0; div_wr = 1'b0; entry_wr = 1'b0;
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_cfg(input logic [3:0] d, input logic [17:0] e);
        div_wr = 1'b1; div_data = d; entry_wr = 1'b1; entry_data = e;
        step();
    endtask

    task automatic load(input logic [31:0] v);
        init_wr = 1'b1; init_data = v;
        irq_seen = 0;
        step();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        req = "R1";
        chk("R1", "reset count", cur_count, 0);
        chk("R1", "reset irq", irq_valid, 0);
        chk("R1", "reset div", div_readback, 0);
        chk("R1", "reset entry", entry_readback, 'h10000);
        run_n(5);

        // R3 code 7 (divide by 1), R5 one-shot, R7 vector
        req = "R3";
        set_cfg(4'hF, 18'h3FF41 & 18'h000FF);
        load(32'd5);
        run_n(20);
        chk("R5", "one-shot irq total", irq_seen, 1);
        chk("R5", "one-shot final count", cur_count, 0);

        // R2 bit 2 dropped: 0x4 stores 0 -> shift 1
        req = "R2";
        set_cfg(4'h4, 18'h00041);
        chk("R2", "div bit2 dropped", div_readback, 0);
        load(32'd3);
        run_n(30);
        chk("R5", "one-shot irq total shift1", irq_seen, 1);

        // R6 periodic, code 4 -> shift 5, period 3*32
        req = "R6";
        set_cfg(4'h8, 18'h20090);
        load(32'd2);
        run_n(300);
        chk("R6", "periodic irq total", irq_seen, 300 / (3 * 32));

        // R8 masked periodic
        req = "R8";
        set_cfg(4'hB, 18'h30033);
        load(32'd2);
        run_n(30);
        chk("R8", "masked irq total", irq_seen, 0);

        // R9 zero write stops
        req = "R9";
        set_cfg(4'hB, 18'h20055);
        load(32'd4);
        run_n(3);
        load(32'd0);
        run_n(40);
        chk("R9", "stopped irq total", irq_seen, 0);
        chk("R9", "stopped count", cur_count, 0);

        // R4 restart mid-countdown, code 1 -> shift 2, period 16
        req = "R4";
        set_cfg(4'h1, 18'h20066);
        load(32'd3);
        run_n(10);
        load(32'd3);
        run_n(15);
        chk("R4", "no irq before restarted period", irq_seen, 0);
        run_n(1);
        chk("R4", "irq at restarted period", irq_seen, 1);

        // R3 code 6 -> shift 7 (divide by 128), R10 entry bits filtered
        req = "R10";
        set_cfg(4'hA, 18'h0FFC7);
        chk("R10", "entry filtered", entry_readback, 'h000C7);
        req = "R3";
        load(32'd1);
        run_n(255);
        chk("R3", "no irq before 256 clocks", irq_seen, 0);
        run_n(5);
        chk("R3", "irq after 256 clocks", irq_seen, 1);

        finish_run();
    end

endmodule